// File: doc/BRIEF.md
# Vector Unpack Engine

This block carries out one unpack command. Packed operand data follows the command word as a continuous bit stream. The engine expands each packed element into a 32-bit lane of a 128-bit vector and writes one vector per clock to vector memory. The shape of the packed data comes from a four-bit code in the command. The code gives the lane count and the element width, and one code selects a 16-bit format with 5-5-5-1 lanes. Sign extension, a base address and an optional relative offset come from the immediate.

A cycle setting (a read count and a write count) chooses between two addressing patterns. In the first, destination rows are skipped. In the second, some vectors are filled instead of being read from the stream. An optional mask gives every lane a 2-bit code. The code picks one of four sources for that lane: the unpacked data, a per-lane row fill word, a per-row column fill word, or no write, which leaves the old memory contents in place.

The operand source answers a bit-offset read. The engine presents the bit offset of the next vector in the stream. The source returns the 128 bits that start at that offset in the same cycle.

Top module: `vunpack_engine`

## Requirements
- R1: `cmd[3:2]` holds the lane count minus one (vn) and `cmd[1:0]` holds the size code (vl). For vl below 3 the element width is 32>>vl bits. Lanes 0..vn carry elements taken from the stream starting at bit 0 of `rd_bits`, lane i at i times the element width. Lanes above vn are written as zero.
- R2: The packed vector width is the element width times (vn+1). `rd_bitoff` is 0 for the first stream vector and grows by the vector width for each vector taken from the stream.
- R3: vl=3 with vn=3 is a 16-bit format. Lanes 0, 1 and 2 are 5 bits wide at bits 4:0, 9:5 and 14:10. Lane 3 is the single bit 15.
- R4: `imm[14]`=1 sign-extends each lane from its top bit, including the 1-bit lane. With `imm[14]`=0 each lane is zero-extended.
- R5: vl=3 with any vn other than 3 is illegal. An illegal command raises `err`, makes no memory write and pulses `done`. `err` holds until the next start, and a legal start clears it.
- R6: Outside a command the engine sits idle with `remaining` at 0. A start loads `remaining` with `num`, and `remaining` drops by one on every write. `done` pulses for one cycle after the last write. With `num`=0 the engine makes no write and pulses `done`.
- R7: The destination base in quadword units is `imm[9:0]`. When `imm[15]`=1 and ENGINE_ID is 1, `base_ofs` is added to it. With `cyc_wl`=0 or `cyc_cl`<`cyc_wl`, vector k is written to base+k.
- R8: With `cyc_wl`>0 and `cyc_cl`>=`cyc_wl`, vector k is written to base + `cyc_cl`*(k div `cyc_wl`) + (k mod `cyc_wl`).
- R9: With `cyc_cl`<`cyc_wl`, a vector whose k mod `cyc_wl` is at least `cyc_cl` is filled. Its unpacked lanes are zero and it consumes no stream bits.
- R10: With `cmd[4]`=1, lane i of vector k uses the code in `mask_reg` at bit 8*row+2*i, where row is (k mod `cyc_wl`) mod 4, or 0 when `cyc_wl`=0. The codes are: 0 = unpacked data, 1 = `row_fill` word i, 2 = `col_fill` word row, 3 = lane enable low.
- R11: With `cmd[4]`=0, all four lane enables are high and every lane carries the unpacked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; ignored while busy |
| cmd | input | 5 | Mask enable, lane count, size code |
| imm | input | 16 | Relative flag, sign flag, base address |
| num | input | NUM_W | Number of output vectors |
| cyc_cl | input | 8 | Cycle read count |
| cyc_wl | input | 8 | Cycle write count |
| base_ofs | input | 10 | Offset added for relative commands |
| mask_reg | input | 32 | Four rows of four 2-bit lane codes |
| row_fill | input | 128 | Fill words indexed by lane |
| col_fill | input | 128 | Fill words indexed by cycle row |
| rd_bitoff | output | BOFF_W | Bit offset of the next stream vector |
| rd_bits | input | 128 | Stream bits starting at rd_bitoff |
| mem_we | output | 1 | Vector write strobe |
| mem_addr | output | ADDR_W | Quadword write address |
| mem_wdata | output | 128 | Write data, lane i at bits 32i+31:32i |
| mem_lane_en | output | 4 | Per-lane write enable |
| remaining | output | NUM_W | Vectors still to be written |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Last command was illegal |

## Verification
The hardest cases to reach are those where the cycle counter, the stream offset and the mask row move apart. This happens when fill vectors sit between stream vectors, and when the column fill word is indexed by a row other than zero. The bench reaches them by running short commands with small cycle settings (read 1 of 3, and read 3 with write 2) over a known stream. Each written vector's address is then compared against the requirement formulas, and the stream words must appear in order with the filled rows skipped. A masked command with read and write counts of two selects the second mask row, which shows that the column word follows the row index and not the lane.

// File: rtl/vunpack_pkg.sv
package vunpack_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 32;
    localparam int VEC_W  = LANES * LANE_W;

    typedef enum logic [1:0] {
        MSEL_DATA = 2'd0,
        MSEL_ROW  = 2'd1,
        MSEL_COL  = 2'd2,
        MSEL_KEEP = 2'd3
    } msel_e;

    typedef struct packed {
        logic       legal;
        logic       pack5;
        logic [5:0] ew;
        logic [7:0] vw;
    } shape_t;

    function automatic shape_t decode_shape(input logic [1:0] vn, input logic [1:0] vl);
        shape_t s;
        s.legal = 1'b1;
        s.pack5 = 1'b0;
        s.ew    = 6'd0;
        s.vw    = 8'd0;
        if (vl != 2'd3) begin
            s.ew = 6'd32 >> vl;
            s.vw = 8'({2'b00, s.ew} * ({6'b0, vn} + 8'd1));
        end else if (vn == 2'd3) begin
            s.pack5 = 1'b1;
            s.ew    = 6'd5;
            s.vw    = 8'd16;
        end else begin
            s.legal = 1'b0;
        end
        return s;
    endfunction

endpackage

// File: rtl/vunpack_lane.sv
module vunpack_lane
    import vunpack_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [VEC_W-1:0]  vec_bits,
    input  shape_t            shp,
    input  logic [1:0]        vn,
    input  logic              sx,
    input  logic              fill,
    input  logic              mask_en,
    input  logic [1:0]        code,
    input  logic [LANE_W-1:0] row_word,
    input  logic [LANE_W-1:0] col_word,
    output logic [LANE_W-1:0] lane_data,
    output logic              lane_en
);

    logic [6:0]        off;
    logic [5:0]        w;
    logic [LANE_W-1:0] raw;
    logic [LANE_W-1:0] lmask;
    logic [LANE_W-1:0] sbit;
    logic [LANE_W-1:0] val;
    logic              active;
    msel_e             sel;

    always_comb begin
        off    = 7'(LANE_IDX) * {1'b0, shp.ew};
        w      = (shp.pack5 && LANE_IDX == 3) ? 6'd1 : shp.ew;
        raw    = LANE_W'(vec_bits >> off);
        lmask  = (w >= 6'd32) ? '1 : ((32'd1 << w) - 32'd1);
        sbit   = raw >> (w - 6'd1);
        val    = raw & lmask;
        if (sx && sbit[0])
            val = val | ~lmask;
        active = (2'(LANE_IDX) <= vn) && !fill;
        if (!active)
            val = '0;
        sel = msel_e'(code);
        lane_data = val;
        lane_en   = 1'b1;
        if (mask_en) begin
            case (sel)
                MSEL_ROW:  lane_data = row_word;
                MSEL_COL:  lane_data = col_word;
                MSEL_KEEP: lane_en   = 1'b0;
                default:   lane_data = val;
            endcase
        end
    end

endmodule

// File: rtl/vunpack_seq.sv
module vunpack_seq #(
    parameter int ENGINE_ID = 1,
    parameter int NUM_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int BOFF_W    = NUM_W + 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              legal_in,
    input  logic [7:0]        vw_in,
    input  logic [4:0]        cmd_in,
    input  logic              sx_in,
    input  logic              rel_in,
    input  logic [9:0]        base_in,
    input  logic [9:0]        base_ofs,
    input  logic [NUM_W-1:0]  num_in,
    input  logic [7:0]        cl_in,
    input  logic [7:0]        wl_in,
    output logic              busy,
    output logic [NUM_W-1:0]  remaining,
    output logic              done,
    output logic              err,
    output logic [7:0]        row,
    output logic              fill,
    output logic [BOFF_W-1:0] boff,
    output logic [ADDR_W-1:0] addr,
    output logic [4:0]        cmd_q,
    output logic              sx_q
);

    logic [7:0]        cl_q;
    logic [7:0]        wl_q;
    logic [7:0]        vw_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] blk;
    logic [ADDR_W-1:0] ofs_add;
    logic              linear;

    generate
        if (ENGINE_ID == 1) begin : g_rel
            assign ofs_add = rel_in ? ADDR_W'(base_ofs) : '0;
        end else begin : g_abs
            assign ofs_add = '0;
        end
    endgenerate

    assign fill   = busy && (wl_q != 8'd0) && (cl_q < wl_q) && (row >= cl_q);
    assign linear = (wl_q == 8'd0) || (cl_q < wl_q);
    assign addr   = base_q + blk + ADDR_W'(row);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            remaining <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            row       <= '0;
            blk       <= '0;
            boff      <= '0;
            base_q    <= '0;
            cl_q      <= '0;
            wl_q      <= '0;
            vw_q      <= '0;
            cmd_q     <= '0;
            sx_q      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    err    <= !legal_in;
                    cl_q   <= cl_in;
                    wl_q   <= wl_in;
                    vw_q   <= vw_in;
                    cmd_q  <= cmd_in;
                    sx_q   <= sx_in;
                    base_q <= ADDR_W'(base_in) + ofs_add;
                    row    <= '0;
                    blk    <= '0;
                    boff   <= '0;
                    remaining <= legal_in ? num_in : '0;
                    if (legal_in && num_in != '0)
                        busy <= 1'b1;
                    else
                        done <= 1'b1;
                end
            end else begin
                remaining <= remaining - NUM_W'(1);
                if (remaining == NUM_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                if (!fill)
                    boff <= boff + BOFF_W'(vw_q);
                if (wl_q == 8'd0) begin
                    blk <= blk + ADDR_W'(1);
                end else if (row == wl_q - 8'd1) begin
                    row <= '0;
                    blk <= blk + ADDR_W'((cl_q >= wl_q) ? cl_q : wl_q);
                end else begin
                    row <= row + 8'd1;
                end
            end
        end
    end

    // R6: one vector per busy cycle
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> (remaining == $past(remaining) - NUM_W'(1)));

    // R6: command ends with nothing left
    assert_end_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (remaining == '0));

    // R7: linear addressing steps by one quadword
    assert_linear_step_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && linear) |-> (addr == $past(addr) + ADDR_W'(1)));

    // R9: a filled vector consumes no stream bits
    assert_fill_holds_offset_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(fill)) |-> (boff == $past(boff)));

    // R2: stream read starts at bit zero
    assert_stream_origin_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (boff == '0));

endmodule

// File: rtl/vunpack_engine.sv
module vunpack_engine
    import vunpack_pkg::*;
#(
    parameter int ENGINE_ID = 1,
    parameter int NUM_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int BOFF_W    = NUM_W + 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [4:0]        cmd,
    input  logic [15:0]       imm,
    input  logic [NUM_W-1:0]  num,
    input  logic [7:0]        cyc_cl,
    input  logic [7:0]        cyc_wl,
    input  logic [9:0]        base_ofs,
    input  logic [31:0]       mask_reg,
    input  logic [127:0]      row_fill,
    input  logic [127:0]      col_fill,
    output logic [BOFF_W-1:0] rd_bitoff,
    input  logic [127:0]      rd_bits,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [127:0]      mem_wdata,
    output logic [3:0]        mem_lane_en,
    output logic [NUM_W-1:0]  remaining,
    output logic              busy,
    output logic              done,
    output logic              err
);

    shape_t            shp_in;
    shape_t            shp_q;
    logic [4:0]        cmd_q;
    logic              sx_q;
    logic [7:0]        row;
    logic [1:0]        row_idx;
    logic              fill;
    logic [LANES-1:0]  en_v;
    logic [LANE_W-1:0] col_word;

    assign shp_in  = decode_shape(cmd[3:2], cmd[1:0]);
    assign shp_q   = decode_shape(cmd_q[3:2], cmd_q[1:0]);
    assign row_idx = row[1:0];
    assign col_word = col_fill[32*row_idx +: 32];

    vunpack_seq #(
        .ENGINE_ID (ENGINE_ID),
        .NUM_W     (NUM_W),
        .ADDR_W    (ADDR_W),
        .BOFF_W    (BOFF_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .legal_in  (shp_in.legal),
        .vw_in     (shp_in.vw),
        .cmd_in    (cmd),
        .sx_in     (imm[14]),
        .rel_in    (imm[15]),
        .base_in   (imm[9:0]),
        .base_ofs  (base_ofs),
        .num_in    (num),
        .cl_in     (cyc_cl),
        .wl_in     (cyc_wl),
        .busy      (busy),
        .remaining (remaining),
        .done      (done),
        .err       (err),
        .row       (row),
        .fill      (fill),
        .boff      (rd_bitoff),
        .addr      (mem_addr),
        .cmd_q     (cmd_q),
        .sx_q      (sx_q)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            vunpack_lane #(.LANE_IDX(i)) u_lane (
                .vec_bits  (rd_bits),
                .shp       (shp_q),
                .vn        (cmd_q[3:2]),
                .sx        (sx_q),
                .fill      (fill),
                .mask_en   (cmd_q[4]),
                .code      (mask_reg[8*row_idx + 2*i +: 2]),
                .row_word  (row_fill[32*i +: 32]),
                .col_word  (col_word),
                .lane_data (mem_wdata[32*i +: 32]),
                .lane_en   (en_v[i])
            );
        end
    endgenerate

    assign mem_we      = busy;
    assign mem_lane_en = busy ? en_v : 4'b0000;

    // R5: an illegal command never writes
    assert_err_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        err |-> !mem_we);

    // R11: without masking every lane is written
    assert_full_lanes_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !cmd_q[4]) |-> (mem_lane_en == 4'b1111));

endmodule

// File: tb/sim_vunpack_engine.sv
module sim_vunpack_engine;

    localparam int NUM_W  = 8;
    localparam int ADDR_W = 12;
    localparam int BOFF_W = NUM_W + 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [4:0]        cmd = '0;
    logic [15:0]       imm = '0;
    logic [NUM_W-1:0]  num = '0;
    logic [7:0]        cyc_cl = '0;
    logic [7:0]        cyc_wl = '0;
    logic [9:0]        base_ofs = '0;
    logic [31:0]       mask_reg = '0;
    logic [127:0]      row_fill = '0;
    logic [127:0]      col_fill = '0;
    logic [BOFF_W-1:0] rd_bitoff;
    logic [127:0]      rd_bits;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0]      mem_wdata;
    logic [3:0]        mem_lane_en;
    logic [NUM_W-1:0]  remaining;
    logic              busy;
    logic              done;
    logic              err;

    logic [1023:0]     strm = '0;
    logic [1023:0]     shifted;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;

    logic [ADDR_W-1:0] log_addr [64];
    logic [127:0]      log_data [64];
    logic [3:0]        log_en   [64];
    logic [NUM_W-1:0]  log_rem  [64];
    int                wcount = 0;

    always #2 clk = ~clk;

    always_comb begin
        shifted = strm >> rd_bitoff;
        rd_bits = shifted[127:0];
    end

    vunpack_engine #(.ENGINE_ID(1), .NUM_W(NUM_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .imm(imm), .num(num),
        .cyc_cl(cyc_cl), .cyc_wl(cyc_wl), .base_ofs(base_ofs), .mask_reg(mask_reg),
        .row_fill(row_fill), .col_fill(col_fill), .rd_bitoff(rd_bitoff),
        .rd_bits(rd_bits), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_lane_en(mem_lane_en), .remaining(remaining),
        .busy(busy), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (mem_we && wcount < 64) begin
            log_addr[wcount] = mem_addr;
            log_data[wcount] = mem_wdata;
            log_en[wcount]   = mem_lane_en;
            log_rem[wcount]  = remaining;
            wcount = wcount + 1;
        end
    end

    task automatic summary_and_end();
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 100000) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            summary_and_end();
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_wr(input string tag, input int idx, input logic [ADDR_W-1:0] a,
                          input logic [127:0] d, input logic [3:0] en);
        logic [127:0] m;
        chk({tag, " write present"}, 128'(wcount > idx), 128'd1);
        if (wcount > idx) begin
            for (int i = 0; i < 4; i++) m[32*i +: 32] = {32{en[i]}};
            chk({tag, " addr"}, 128'(log_addr[idx]), 128'(a));
            chk({tag, " lane_en"}, 128'(log_en[idx]), 128'(en));
            chk({tag, " data"}, log_data[idx] & m, d & m);
        end
    endtask

    task automatic set_word(input int idx, input logic [31:0] v);
        strm[32*idx +: 32] = v;
    endtask

    task automatic run_cmd(input logic [4:0] c, input logic [15:0] im, input int n);
        int guard;
        wcount = 0;
        @(negedge clk);
        cmd = c;
        imm = im;
        num = NUM_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        chk("R6 done pulse seen", 128'(done), 128'd1);
    endtask

    task automatic t_reset();
        chk("R6 reset busy", 128'(busy), 128'd0);
        chk("R6 reset done", 128'(done), 128'd0);
        chk("R5 reset err", 128'(err), 128'd0);
        chk("R6 reset remaining", 128'(remaining), 128'd0);
        chk("R6 reset mem_we", 128'(mem_we), 128'd0);
    endtask

    task automatic t_v4_32();
        strm = '0;
        for (int i = 0; i < 8; i++) set_word(i, 32'h1111_0000 + i);
        cyc_cl = 0; cyc_wl = 0; mask_reg = '0;
        run_cmd(5'b01100, 16'h0005, 2);
        chk("R6 write count", 128'(wcount), 128'd2);
        chk_wr("R1 R2 R7 R11 v4_32 #0", 0, 12'h005,
               {32'h1111_0003, 32'h1111_0002, 32'h1111_0001, 32'h1111_0000}, 4'b1111);
        chk_wr("R2 R7 v4_32 #1", 1, 12'h006,
               {32'h1111_0007, 32'h1111_0006, 32'h1111_0005, 32'h1111_0004}, 4'b1111);
        chk("R6 remaining first", 128'(log_rem[0]), 128'd2);
        chk("R6 remaining second", 128'(log_rem[1]), 128'd1);
        chk("R6 remaining after", 128'(remaining), 128'd0);
    endtask

    task automatic t_v2_16();
        strm = '0;
        set_word(0, 32'h8001_7FFF);
        set_word(1, 32'h0002_FFFE);
        run_cmd(5'b00101, 16'h4000, 2);
        chk_wr("R4 R1 v2_16 signed #0", 0, 12'h000, {64'h0, 32'hFFFF_8001, 32'h0000_7FFF}, 4'b1111);
        chk_wr("R4 R2 v2_16 signed #1", 1, 12'h001, {64'h0, 32'h0000_0002, 32'hFFFF_FFFE}, 4'b1111);
        run_cmd(5'b00101, 16'h0000, 1);
        chk_wr("R4 v2_16 unsigned", 0, 12'h000, {64'h0, 32'h0000_8001, 32'h0000_7FFF}, 4'b1111);
    endtask

    task automatic t_s_8();
        strm = '0;
        strm[15:0] = 16'h1285;
        run_cmd(5'b00010, 16'h0000, 2);
        chk_wr("R1 R2 s_8 #0", 0, 12'h000, {96'h0, 32'h0000_0085}, 4'b1111);
        chk_wr("R1 R2 s_8 #1", 1, 12'h001, {96'h0, 32'h0000_0012}, 4'b1111);
    endtask

    task automatic t_5551();
        strm = '0;
        strm[15:0]  = 16'hFC71;
        strm[31:16] = 16'h0001;
        run_cmd(5'b01111, 16'h0000, 2);
        chk_wr("R3 5551 unsigned #0", 0, 12'h000,
               {32'h1, 32'h1F, 32'h3, 32'h11}, 4'b1111);
        chk_wr("R3 R2 5551 #1", 1, 12'h001, {96'h0, 32'h1}, 4'b1111);
        run_cmd(5'b01111, 16'h4000, 1);
        chk_wr("R3 R4 5551 signed", 0, 12'h000,
               {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h3, 32'hFFFF_FFF1}, 4'b1111);
    endtask

    task automatic t_illegal();
        run_cmd(5'b00011, 16'h0000, 3);
        chk("R5 illegal err", 128'(err), 128'd1);
        chk("R5 illegal no write", 128'(wcount), 128'd0);
        chk("R5 illegal remaining", 128'(remaining), 128'd0);
    endtask

    task automatic t_zero();
        run_cmd(5'b00000, 16'h0000, 0);
        chk("R6 zero count no write", 128'(wcount), 128'd0);
        chk("R5 legal start clears err", 128'(err), 128'd0);
    endtask

    task automatic t_skip();
        strm = '0;
        for (int i = 0; i < 8; i++) set_word(i, 32'hB000_0000 + i);
        cyc_cl = 3; cyc_wl = 2;
        run_cmd(5'b00000, 16'h0010, 5);
        chk_wr("R8 skip k0", 0, 12'h010, {96'h0, 32'hB000_0000}, 4'b1111);
        chk_wr("R8 skip k1", 1, 12'h011, {96'h0, 32'hB000_0001}, 4'b1111);
        chk_wr("R8 skip k2", 2, 12'h013, {96'h0, 32'hB000_0002}, 4'b1111);
        chk_wr("R8 skip k3", 3, 12'h014, {96'h0, 32'hB000_0003}, 4'b1111);
        chk_wr("R8 skip k4", 4, 12'h016, {96'h0, 32'hB000_0004}, 4'b1111);
    endtask

    task automatic t_fill();
        strm = '0;
        for (int i = 0; i < 8; i++) set_word(i, 32'hD000_0000 + i);
        cyc_cl = 1; cyc_wl = 3;
        run_cmd(5'b00000, 16'h0020, 5);
        chk_wr("R9 R7 fill k0 data", 0, 12'h020, {96'h0, 32'hD000_0000}, 4'b1111);
        chk_wr("R9 fill k1 zero", 1, 12'h021, 128'h0, 4'b1111);
        chk_wr("R9 fill k2 zero", 2, 12'h022, 128'h0, 4'b1111);
        chk_wr("R9 fill k3 next word", 3, 12'h023, {96'h0, 32'hD000_0001}, 4'b1111);
        chk_wr("R9 fill k4 zero", 4, 12'h024, 128'h0, 4'b1111);
    endtask

    task automatic t_mask();
        strm = '0;
        set_word(0, 32'h5555_0000);
        set_word(1, 32'h5555_0001);
        row_fill = {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000};
        col_fill = {32'hC000_0003, 32'hC000_0002, 32'hC000_0001, 32'hC000_0000};
        cyc_cl = 0; cyc_wl = 0;
        mask_reg = 32'h0000_00E4;
        run_cmd(5'b11100, 16'h0000, 1);
        chk_wr("R10 codes 0/1/2/3", 0, 12'h000,
               {32'h0, 32'hC000_0000, 32'hA000_0001, 32'h5555_0000}, 4'b0111);
        cyc_cl = 2; cyc_wl = 2;
        mask_reg = 32'h0000_0200;
        run_cmd(5'b10000, 16'h0030, 2);
        chk_wr("R10 row0 data", 0, 12'h030, {96'h0, 32'h5555_0000}, 4'b1111);
        chk_wr("R10 row1 column word", 1, 12'h031, {96'h0, 32'hC000_0001}, 4'b1111);
        mask_reg = '0;
    endtask

    task automatic t_relative();
        strm = '0;
        set_word(0, 32'h7777_0000);
        cyc_cl = 0; cyc_wl = 0;
        base_ofs = 10'h100;
        run_cmd(5'b00000, 16'h8004, 1);
        chk_wr("R7 relative base", 0, 12'h104, {96'h0, 32'h7777_0000}, 4'b1111);
        run_cmd(5'b00000, 16'h0004, 1);
        chk_wr("R7 absolute base", 0, 12'h004, {96'h0, 32'h7777_0000}, 4'b1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_v4_32();
        t_v2_16();
        t_s_8();
        t_5551();
        t_illegal();
        t_zero();
        t_skip();
        t_fill();
        t_mask();
        t_relative();
        summary_and_end();
    end

endmodule